// File: doc/BRIEF.md
# Packed Four-Lane Vector Move and Logic Unit

This block executes data-movement, bitwise and compare operations on 128-bit vectors. Each vector is treated as four 32-bit lanes holding single-precision values. Lane 0 is bits 31:0 and lane 3 is bits 127:96. The operands come from a local file of eight 128-bit vector registers. The file has two read ports (indices `srcAIdx`, `srcBIdx`) and one write port (index `dstIdx`). Operand A is read at `srcAIdx` and operand B at `srcBIdx`. The 4-bit `opCode` selects the operation.

The combinational result of the selected operation is always visible on `resultOut`. It is written into register `dstIdx` at the rising clock edge when `opValid` is high. A pipeline or sequencer feeds the block vectors through the load operation. It reads registers back by presenting the plain move operation with `opValid` low and watching `resultOut`.

Top module: `vec_lane_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero and clears `signMask` to zero.
- R2: Opcode 0 (load) writes `loadData` into register `dstIdx`. Opcode 1 (move) copies operand A. No register changes when `opValid` is low.
- R3: Opcode 2 (upper-to-lower half move) produces {A[127:64], B[127:64]}. With A naming the destination, this keeps the destination's upper half and copies the source's upper half into the lower half.
- R4: Opcode 3 (lower-to-upper half move) produces {B[63:0], A[63:0]}.
- R5: Opcode 4 (high interleave) produces lanes 3..0 = [B3, A3, B2, A2].
- R6: Opcode 5 (low interleave) produces lanes 3..0 = [B1, A1, B0, A0].
- R7: Opcode 6 (sign extract) loads `signMask` bit i with bit 31 of lane i of A. It writes no register. `signMask` holds its value until the next valid sign extract.
- R8: Opcodes 7, 9 and 10 give the bitwise AND, OR and XOR of A and B over all 128 bits.
- R9: Opcode 8 gives (NOT A) AND B over all 128 bits.
- R10: Opcode 11 sets each lane to 0xFFFFFFFF when A equals B as single-precision values, and to 0x00000000 otherwise. +0 equals -0, and a NaN in either lane gives false.
- R11: Opcode 12 sets each lane to all ones when A is less than B as single-precision values, and to all zeros otherwise. Negative values order below positive values, -0 is not below +0, and a NaN gives false.
- R12: Opcodes 13 to 15 write no register and leave `signMask` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Commits the current operation at the clock edge |
| opCode | input | 4 | Operation select |
| dstIdx | input | 3 | Destination register index |
| srcAIdx | input | 3 | Operand A register index |
| srcBIdx | input | 3 | Operand B register index |
| loadData | input | 128 | Vector written by the load operation |
| resultOut | output | 128 | Combinational result of the selected operation |
| signMask | output | 4 | Captured lane sign bits |

## Verification
The bench builds the unit with its default parameters: four 32-bit lanes and eight registers. With these values every register index can be reset-checked through the read-back path. Each lane position gets a distinct hex pattern, so a swapped lane or half in the interleave and half-move paths shows up directly. The compare vectors place signed zeros, quiet and signalling NaNs, infinities and mixed signs in individual lanes. This exercises every branch of the lane comparator within one vector.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int LANE_W = 1 + EXP_W + MAN_W;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [3:0] {
    OP_LOAD   = 4'd0,
    OP_MOVE   = 4'd1,
    OP_MOVHL  = 4'd2,
    OP_MOVLH  = 4'd3,
    OP_UNPKHI = 4'd4,
    OP_UNPKLO = 4'd5,
    OP_SGNMSK = 4'd6,
    OP_AND    = 4'd7,
    OP_ANDN   = 4'd8,
    OP_OR     = 4'd9,
    OP_XOR    = 4'd10,
    OP_CMPEQ  = 4'd11,
    OP_CMPLT  = 4'd12
  } vop_e;

  typedef struct packed {
    logic wrEn;
    logic sgnEn;
    vop_e kind;
  } vstrb_t;

  function automatic logic isNan(lane_t v);
    return (&v[LANE_W-2 -: EXP_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic bothZero(lane_t a, lane_t b);
    return (a[LANE_W-2:0] == '0) && (b[LANE_W-2:0] == '0);
  endfunction

  function automatic logic fpEq(lane_t a, lane_t b);
    if (isNan(a) || isNan(b)) return 1'b0;
    return (a == b) || bothZero(a, b);
  endfunction

  function automatic logic fpLt(lane_t a, lane_t b);
    logic sa, sb;
    sa = a[LANE_W-1];
    sb = b[LANE_W-1];
    if (isNan(a) || isNan(b) || bothZero(a, b)) return 1'b0;
    if (sa != sb) return sa;
    if (!sa) return a[LANE_W-2:0] < b[LANE_W-2:0];
    return a[LANE_W-2:0] > b[LANE_W-2:0];
  endfunction
endpackage

// File: rtl/vlu_ctrl.sv
module vlu_ctrl
  import vlu_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output vstrb_t     strb
);
  logic known;

  always_comb begin
    known      = (opCode <= OP_CMPLT);
    strb.kind  = vop_e'(opCode);
    strb.sgnEn = opValid && (opCode == OP_SGNMSK);
    strb.wrEn  = opValid && known && (opCode != OP_SGNMSK);
  end
endmodule

// File: rtl/vlu_regfile.sv
module vlu_regfile #(
  parameter int DEPTH = 8,
  parameter int VEC_W = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VEC_W-1:0] wrData,
  output logic [VEC_W-1:0] rdDataA,
  output logic [VEC_W-1:0] rdDataB
);
  logic [VEC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
  end

  assign rdDataA = mem[rdIdxA];
  assign rdDataB = mem[rdIdxB];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rdDataA == '0 && rdDataB == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> mem[$past(wrIdx)] == $past(wrData)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !$isunknown(rdIdxA)) ##1 $stable(rdIdxA) |-> $stable(rdDataA)); // R2
endmodule

// File: rtl/vlu_datapath.sv
module vlu_datapath
  import vlu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VEC_W = LANES * LANE_W,
  localparam int HALF  = VEC_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  vstrb_t           strb,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] loadData,
  output logic [VEC_W-1:0] result,
  output logic [LANES-1:0] signMask
);
  lane_t aL [LANES];
  lane_t bL [LANES];
  logic [VEC_W-1:0] unpkHi, unpkLo, cmpEq, cmpLt;
  logic [LANES-1:0] signNow;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign aL[i] = opA[i*LANE_W +: LANE_W];
    assign bL[i] = opB[i*LANE_W +: LANE_W];
    if (i % 2 == 1) begin : gOdd
      assign unpkHi[i*LANE_W +: LANE_W] = bL[LANES/2 + i/2];
      assign unpkLo[i*LANE_W +: LANE_W] = bL[i/2];
    end else begin : gEven
      assign unpkHi[i*LANE_W +: LANE_W] = aL[LANES/2 + i/2];
      assign unpkLo[i*LANE_W +: LANE_W] = aL[i/2];
    end
    assign cmpEq[i*LANE_W +: LANE_W] = {LANE_W{fpEq(aL[i], bL[i])}};
    assign cmpLt[i*LANE_W +: LANE_W] = {LANE_W{fpLt(aL[i], bL[i])}};
    assign signNow[i] = aL[i][LANE_W-1];

    AST_CMP_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
      (strb.kind == OP_CMPEQ || strb.kind == OP_CMPLT) |->
        (result[i*LANE_W +: LANE_W] == '0 || result[i*LANE_W +: LANE_W] == '1)); // R10
  end

  always_comb begin
    case (strb.kind)
      OP_LOAD:   result = loadData;
      OP_MOVE:   result = opA;
      OP_MOVHL:  result = {opA[VEC_W-1:HALF], opB[VEC_W-1:HALF]};
      OP_MOVLH:  result = {opB[HALF-1:0], opA[HALF-1:0]};
      OP_UNPKHI: result = unpkHi;
      OP_UNPKLO: result = unpkLo;
      OP_AND:    result = opA & opB;
      OP_ANDN:   result = ~opA & opB;
      OP_OR:     result = opA | opB;
      OP_XOR:    result = opA ^ opB;
      OP_CMPEQ:  result = cmpEq;
      OP_CMPLT:  result = cmpLt;
      default:   result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) signMask <= '0;
    else if (strb.sgnEn) signMask <= signNow;
  end
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
  import vlu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REGS  = 8,
  localparam int VEC_W = LANES * LANE_W,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic [VEC_W-1:0] loadData,
  output logic [VEC_W-1:0] resultOut,
  output logic [LANES-1:0] signMask
);
  vstrb_t strb;
  logic [VEC_W-1:0] rdA, rdB;

  vlu_ctrl uCtrl (
    .opValid(opValid),
    .opCode (opCode),
    .strb   (strb)
  );

  vlu_regfile #(.DEPTH(REGS), .VEC_W(VEC_W)) uRegs (
    .clk    (clk),
    .rst    (rst),
    .rdIdxA (srcAIdx),
    .rdIdxB (srcBIdx),
    .wrEn   (strb.wrEn),
    .wrIdx  (dstIdx),
    .wrData (resultOut),
    .rdDataA(rdA),
    .rdDataB(rdB)
  );

  vlu_datapath #(.LANES(LANES)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opA     (rdA),
    .opB     (rdB),
    .loadData(loadData),
    .result  (resultOut),
    .signMask(signMask)
  );

  AST_SGN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OP_SGNMSK) |-> !strb.wrEn); // R7

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opCode > OP_CMPLT) |-> !strb.wrEn); // R12

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(opValid && opCode == OP_SGNMSK) |=> $stable(signMask)); // R7
endmodule

// File: tb/vec_lane_unit_test.sv
module vec_lane_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic [3:0]   opCode = 4'd1;
  logic [2:0]   dstIdx = '0, srcAIdx = '0, srcBIdx = '0;
  logic [127:0] loadData = '0;
  logic [127:0] resultOut;
  logic [3:0]   signMask;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  vec_lane_unit uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .loadData(loadData), .resultOut(resultOut), .signMask(signMask)
  );

  typedef struct packed {
    logic [3:0]   op;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
  } vrow_t;

  localparam logic [127:0] VA = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] VB = 128'hAAAAAAAA_BBBBBBBB_CCCCCCCC_DDDDDDDD;
  localparam int NROWS = 12;
  localparam vrow_t ROWS [NROWS] = '{
    '{4'd1,  VA, VB, VA},                                                   // R2
    '{4'd2,  VA, VB, 128'h11111111_22222222_AAAAAAAA_BBBBBBBB},             // R3
    '{4'd3,  VA, VB, 128'hCCCCCCCC_DDDDDDDD_33333333_44444444},             // R4
    '{4'd4,  VA, VB, 128'hAAAAAAAA_11111111_BBBBBBBB_22222222},             // R5
    '{4'd5,  VA, VB, 128'hCCCCCCCC_33333333_DDDDDDDD_44444444},             // R6
    '{4'd7,  VA, VB, 128'h00000000_22222222_00000000_44444444},             // R8
    '{4'd9,  VA, VB, 128'hBBBBBBBB_BBBBBBBB_FFFFFFFF_DDDDDDDD},             // R8
    '{4'd10, VA, VB, 128'hBBBBBBBB_99999999_FFFFFFFF_99999999},             // R8
    '{4'd8,  VA, VB, 128'hAAAAAAAA_99999999_CCCCCCCC_99999999},             // R9
    '{4'd11, 128'h3F800000_80000000_7FC00000_40000000,
             128'h3F800000_00000000_7FC00000_40400000,
             128'hFFFFFFFF_FFFFFFFF_00000000_00000000},                     // R10
    '{4'd12, 128'h40000000_C0000000_3F800000_80000000,
             128'h3F800000_BF800000_7FC00000_00000000,
             128'h00000000_FFFFFFFF_00000000_00000000},                     // R11
    '{4'd12, 128'hFF800000_3F800000_7F800001_40000000,
             128'hC0000000_40000000_3F800000_40000000,
             128'hFFFFFFFF_FFFFFFFF_00000000_00000000}                      // R11
  };

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd1:               return "R2";
      4'd2:               return "R3";
      4'd3:               return "R4";
      4'd4:               return "R5";
      4'd5:               return "R6";
      4'd7, 4'd9, 4'd10:  return "R8";
      4'd8:               return "R9";
      4'd11:              return "R10";
      default:            return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b, input logic [127:0] data, input logic v);
    @(negedge clk);
    opCode = op; dstIdx = d; srcAIdx = a; srcBIdx = b; loadData = data; opValid = v;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [127:0] val);
    opValid = 1'b0; opCode = 4'd1; srcAIdx = idx;
    #1 val = resultOut;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [127:0] v;
    logic [3:0]   heldMask;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every register and the sign mask are zero after reset
    for (int r = 0; r < 8; r++) begin
      readReg(3'(r), v);
      check("R1", v, '0);
    end
    check("R1", {124'd0, signMask}, '0);

    // R2: load without valid changes nothing; with valid it lands
    runOp(4'd0, 3'd6, 3'd0, 3'd0, VB, 1'b0);
    readReg(3'd6, v);
    check("R2", v, '0);
    runOp(4'd0, 3'd6, 3'd0, 3'd0, VB, 1'b1);
    readReg(3'd6, v);
    check("R2", v, VB);

    // Vector table walk
    for (int k = 0; k < NROWS; k++) begin
      runOp(4'd0, 3'd1, 3'd0, 3'd0, ROWS[k].a, 1'b1);
      runOp(4'd0, 3'd2, 3'd0, 3'd0, ROWS[k].b, 1'b1);
      runOp(ROWS[k].op, 3'd3, 3'd1, 3'd2, '0, 1'b1);
      readReg(3'd3, v);
      check(reqOf(ROWS[k].op), v, ROWS[k].e);
    end

    // R7: sign extract, no write, mask held across other ops
    runOp(4'd0, 3'd4, 3'd0, 3'd0, 128'h80000000_00000000_FFFFFFFF_7FFFFFFF, 1'b1);
    runOp(4'd0, 3'd5, 3'd0, 3'd0, VA, 1'b1);
    runOp(4'd6, 3'd5, 3'd4, 3'd0, '0, 1'b1);
    check("R7", {124'd0, signMask}, {124'd0, 4'b1010});
    readReg(3'd5, v);
    check("R7", v, VA);
    runOp(4'd7, 3'd3, 3'd1, 3'd2, '0, 1'b1);
    check("R7", {124'd0, signMask}, {124'd0, 4'b1010});
    heldMask = signMask;
    runOp(4'd6, 3'd5, 3'd1, 3'd0, '0, 1'b0);
    check("R7", {124'd0, signMask}, {124'd0, heldMask});

    // R12: undefined opcodes write nothing and keep the mask
    runOp(4'd13, 3'd5, 3'd4, 3'd4, VB, 1'b1);
    readReg(3'd5, v);
    check("R12", v, VA);
    runOp(4'd15, 3'd5, 3'd0, 3'd0, VB, 1'b1);
    readReg(3'd5, v);
    check("R12", v, VA);
    check("R12", {124'd0, signMask}, {124'd0, 4'b1010});

    // R1: reset mid-run clears contents again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    readReg(3'd5, v);
    check("R1", v, '0);
    check("R1", {124'd0, signMask}, '0);

    summary();
  end
endmodule